// File: doc/BRIEF.md
# Mixed-Width Element Adder Stage

This stage adds one pair of vector elements when each of the two source operands and the destination carries its own element width. A 2-bit width code per operand selects the full 64-bit register width, 8, 16 or 32 bits. The stage brings both sources to a common operation width and adds them there. It then widens or narrows the sum to the destination width. Three flavours share the datapath. The plain add zero-extends its sources. The word add sign-extends them. The immediate form adds a signed 12-bit constant to the first source.

The stage also works out where the destination element sits in a packed register file of 128 entries of 64 bits each. It takes the base register, the element index and the destination width, and returns the register number and the byte lane. An element may spill past its base register into the registers that follow. When the element would run past the last byte of the file, the stage raises a fault flag instead of a valid result. All outputs are registered, so a request presented in one cycle is answered in the next.

Top module: `pew_adder`

## Requirements
- R1: Width code 0 selects 64 bits, code 1 selects 8 bits, code 2 selects 16 bits and code 3 selects 32 bits. The same decode applies to the first source, the second source and the destination.
- R2: Outside the immediate form, the add runs at the larger of the two source widths, and the sum wraps modulo that width.
- R3: With `word_mode`=0 and `use_imm`=0, a source narrower than the operation width is zero-extended to it.
- R4: With `word_mode`=1 and `use_imm`=0, a source narrower than the operation width is sign-extended from its own top bit. Sources of equal width are added unchanged.
- R5: If the destination width exceeds the operation width, the sum is sign-extended from its top bit. Otherwise it is truncated to the destination width. Bits of `res_data` above the destination width are always zero.
- R6: With `use_imm`=1, `word_mode` has no effect. The add runs at the larger of the first source width and 12 bits. `imm` is sign-extended from bit 11, and the first source is sign-extended when narrower.
- R7: Bits of `opa` and `opb` above their own source width have no effect on the result.
- R8: The destination element starts at byte address base_reg*8 + elem_idx*(destination width/8) in the flat register file. `res_reg` is that address divided by 8, and `res_byte` is the address modulo 8.
- R9: When the element's last byte would lie beyond byte 1023 of the file, `res_fault` is set and `res_valid` stays low for that request.
- R10: Each request with `in_valid`=1 raises exactly one of `res_valid` or `res_fault` in the next cycle. A cycle without `in_valid` leaves both low in the next cycle. Synchronous reset clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| word_mode | input | 1 | 1 = sign-extending word add, 0 = zero-extending plain add |
| use_imm | input | 1 | 1 = add immediate to the first source |
| wcode_a | input | 2 | Width code of the first source |
| wcode_b | input | 2 | Width code of the second source |
| wcode_d | input | 2 | Width code of the destination |
| opa | input | 64 | First source element, right-aligned |
| opb | input | 64 | Second source element, right-aligned |
| imm | input | 12 | Signed immediate |
| base_reg | input | 7 | Destination base register |
| elem_idx | input | 10 | Destination element index |
| res_valid | output | 1 | Registered result valid |
| res_fault | output | 1 | Registered out-of-file fault |
| res_data | output | 64 | Result at destination width, zero above it |
| res_reg | output | 7 | Register holding the destination element |
| res_byte | output | 3 | Byte lane of the element inside that register |

## Verification
The width arithmetic and the element placement share the same cycle, and a fault from placement must cancel a result the adder has already computed. The bench provokes this by aiming requests at the last elements of the file, with the element index chosen so that one element still fits and the next runs one byte or more past the end. These requests carry operands whose sums are non-trivial. The reference model judges each response on the following clock. A fitting element must come back valid with the correct data and location. A spilling element must come back as a fault with `res_valid` low, whatever its sum. Further requests mix every pairing of width codes and modes to separate zero extension, sign extension and destination resizing.

// File: rtl/pew_pkg.sv
package pew_pkg;

  typedef enum logic [1:0] {
    WC_NATIVE = 2'd0,
    WC_BYTE   = 2'd1,
    WC_HALF   = 2'd2,
    WC_WORD   = 2'd3
  } wcode_e;

  // R1: width code to bit count
  function automatic int width_of(input logic [1:0] code, input int xlen);
    case (wcode_e'(code))
      WC_BYTE: return 8;
      WC_HALF: return 16;
      WC_WORD: return 32;
      default: return xlen;
    endcase
  endfunction

endpackage

// File: rtl/pew_operand_ext.sv
module pew_operand_ext #(
  parameter int XLEN = 64,
  localparam int WBW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] din,
  input  logic [WBW-1:0]  src_w,
  input  logic [WBW-1:0]  op_w,
  input  logic            sign_ext,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] mask_src, mask_op, masked;
  logic            msb;

  always_comb begin
    mask_src = (src_w >= WBW'(XLEN)) ? '1 : ~({XLEN{1'b1}} << src_w);
    mask_op  = (op_w  >= WBW'(XLEN)) ? '1 : ~({XLEN{1'b1}} << op_w);
    masked   = din & mask_src;           // R7: drop bits above the width
    msb      = masked[src_w - WBW'(1)];
    if (sign_ext && (src_w < op_w) && msb)
      dout = masked | (mask_op & ~mask_src);   // R4 / R6
    else
      dout = masked;                            // R3
  end
endmodule

// File: rtl/pew_resize.sv
module pew_resize #(
  parameter int XLEN = 64,
  localparam int WBW = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] sum,
  input  logic [WBW-1:0]  op_w,
  input  logic [WBW-1:0]  dst_w,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] mask_op, mask_dst, trimmed;

  always_comb begin
    mask_op  = (op_w  >= WBW'(XLEN)) ? '1 : ~({XLEN{1'b1}} << op_w);
    mask_dst = (dst_w >= WBW'(XLEN)) ? '1 : ~({XLEN{1'b1}} << dst_w);
    trimmed  = sum & mask_op;                   // R2: wrap at op width
    if ((dst_w > op_w) && trimmed[op_w - WBW'(1)])
      dout = (trimmed | ~mask_op) & mask_dst;   // R5: widen signed
    else
      dout = trimmed & mask_dst;                // R5: truncate
  end
endmodule

// File: rtl/pew_elem_locate.sv
module pew_elem_locate #(
  parameter int XLEN = 64,
  parameter int NREG = 128,
  parameter int IDXW = 10,
  localparam int RW  = $clog2(NREG),
  localparam int BYW = $clog2(XLEN/8),
  localparam int WBW = $clog2(XLEN) + 1,
  localparam int AW  = RW + BYW + IDXW + 2,
  localparam int FILE_B = NREG * (XLEN/8)
) (
  input  logic [RW-1:0]   base_reg,
  input  logic [IDXW-1:0] elem_idx,
  input  logic [WBW-1:0]  dst_w,
  output logic [RW-1:0]   loc_reg,
  output logic [BYW-1:0]  loc_byte,
  output logic            fault
);
  logic [AW-1:0] unit_b, addr_b;

  always_comb begin
    unit_b   = AW'(dst_w >> 3);
    addr_b   = (AW'(base_reg) << BYW) + AW'(elem_idx) * unit_b;   // R8
    loc_reg  = addr_b[BYW +: RW];
    loc_byte = addr_b[BYW-1:0];
    fault    = (addr_b + unit_b) > AW'(FILE_B);                  // R9
  end
endmodule

// File: rtl/pew_adder.sv
module pew_adder #(
  parameter int XLEN = 64,
  parameter int NREG = 128,
  parameter int IDXW = 10,
  parameter int IMMW = 12,
  localparam int RW  = $clog2(NREG),
  localparam int BYW = $clog2(XLEN/8),
  localparam int WBW = $clog2(XLEN) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            word_mode,
  input  logic            use_imm,
  input  logic [1:0]      wcode_a,
  input  logic [1:0]      wcode_b,
  input  logic [1:0]      wcode_d,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic [RW-1:0]   base_reg,
  input  logic [IDXW-1:0] elem_idx,
  output logic            res_valid,
  output logic            res_fault,
  output logic [XLEN-1:0] res_data,
  output logic [RW-1:0]   res_reg,
  output logic [BYW-1:0]  res_byte
);
  import pew_pkg::*;

  logic [WBW-1:0]  wa, wb, wd, op_w;
  logic            sign_ext;
  logic [XLEN-1:0] src_data [2];
  logic [WBW-1:0]  src_w    [2];
  logic [XLEN-1:0] ext_data [2];
  logic [XLEN-1:0] sum, sized;
  logic [RW-1:0]   loc_reg;
  logic [BYW-1:0]  loc_byte;
  logic            fault;

  always_comb begin
    wa = WBW'(width_of(wcode_a, XLEN));   // R1
    wb = WBW'(width_of(wcode_b, XLEN));
    wd = WBW'(width_of(wcode_d, XLEN));
    sign_ext    = use_imm | word_mode;
    src_data[0] = opa;
    src_w[0]    = wa;
    src_data[1] = use_imm ? XLEN'(imm) : opb;
    src_w[1]    = use_imm ? WBW'(IMMW) : wb;
    if (use_imm)
      op_w = (wa > WBW'(IMMW)) ? wa : WBW'(IMMW);   // R6
    else
      op_w = (wa > wb) ? wa : wb;                   // R2
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    pew_operand_ext #(.XLEN(XLEN)) u_ext (
      .din      (src_data[s]),
      .src_w    (src_w[s]),
      .op_w     (op_w),
      .sign_ext (sign_ext),
      .dout     (ext_data[s])
    );
  end

  assign sum = ext_data[0] + ext_data[1];

  pew_resize #(.XLEN(XLEN)) u_resize (
    .sum   (sum),
    .op_w  (op_w),
    .dst_w (wd),
    .dout  (sized)
  );

  pew_elem_locate #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW)) u_loc (
    .base_reg (base_reg),
    .elem_idx (elem_idx),
    .dst_w    (wd),
    .loc_reg  (loc_reg),
    .loc_byte (loc_byte),
    .fault    (fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_data  <= '0;
      res_reg   <= '0;
      res_byte  <= '0;
    end else begin
      res_valid <= in_valid & ~fault;   // R9, R10
      res_fault <= in_valid & fault;
      if (in_valid) begin
        res_data <= sized;
        res_reg  <= loc_reg;
        res_byte <= loc_byte;
      end
    end
  end
endmodule

// File: rtl/pew_adder_chk.sv
module pew_adder_chk #(
  parameter int XLEN = 64,
  parameter int BYW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      wcode_d,
  input logic            res_valid,
  input logic            res_fault,
  input logic [XLEN-1:0] res_data,
  input logic [BYW-1:0]  res_byte
);
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_fault));

  p_answer_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (res_valid || res_fault));

  p_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid || res_fault) |-> $past(in_valid));

  p_byte_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(wcode_d) == 2'd1) |-> (res_data[XLEN-1:8] == '0));

  p_align_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(wcode_d) == 2'd3) |-> (res_byte[1:0] == 2'b00));
endmodule

bind pew_adder pew_adder_chk #(.XLEN(XLEN), .BYW(BYW)) u_pew_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .wcode_d   (wcode_d),
  .res_valid (res_valid),
  .res_fault (res_fault),
  .res_data  (res_data),
  .res_byte  (res_byte)
);

// File: tb/pew_adder_bench.sv
module pew_adder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, word_mode = 1'b0, use_imm = 1'b0;
  logic [1:0]  wcode_a = '0, wcode_b = '0, wcode_d = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [11:0] imm = '0;
  logic [6:0]  base_reg = '0;
  logic [9:0]  elem_idx = '0;
  logic        res_valid, res_fault;
  logic [63:0] res_data;
  logic [6:0]  res_reg;
  logic [2:0]  res_byte;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pew_adder u_pew_adder (.*);

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd1) ? 8 : (c == 2'd2) ? 16 : (c == 2'd3) ? 32 : 64;
  endfunction

  function automatic logic [63:0] msk(input int n);
    return (n >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic logic [63:0] ext(input logic [63:0] v, input int n,
                                      input int w, input bit sgn);
    logic [63:0] t;
    t = v & msk(n);
    if (sgn && t[n-1]) t = t | (msk(w) & ~msk(n));
    return t & msk(w);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one request: drive at negedge, judge at the next negedge
  task automatic run(input string tag, input bit wm, input bit ui,
                     input logic [1:0] ca, input logic [1:0] cb,
                     input logic [1:0] cd, input logic [63:0] a,
                     input logic [63:0] b, input logic [11:0] im,
                     input logic [6:0] br, input logic [9:0] ix);
    int na, nb, nd, w, addr, unit;
    logic [63:0] ea, eb, s, r;
    bit flt;
    in_valid = 1'b1; word_mode = wm; use_imm = ui;
    wcode_a = ca; wcode_b = cb; wcode_d = cd;
    opa = a; opb = b; imm = im; base_reg = br; elem_idx = ix;
    na = wbits(ca); nb = wbits(cb); nd = wbits(cd);
    if (ui) begin
      w  = (na > 12) ? na : 12;
      ea = ext(a, na, w, 1'b1);
      eb = ext({52'd0, im}, 12, w, 1'b1);
    end else begin
      w  = (na > nb) ? na : nb;
      ea = ext(a, na, w, wm);
      eb = ext(b, nb, w, wm);
    end
    s = (ea + eb) & msk(w);
    r = (nd > w) ? ext(s, w, nd, 1'b1) : (s & msk(nd));
    unit = nd / 8;
    addr = int'(br) * 8 + int'(ix) * unit;
    flt  = (addr + unit) > 1024;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, "valid", {63'd0, res_valid}, {63'd0, !flt});
    check(tag, "fault", {63'd0, res_fault}, {63'd0, flt});
    if (!flt) begin
      check(tag, "data", res_data, r);
      check(tag, "reg",  {57'd0, res_reg},  64'(addr / 8));
      check(tag, "byte", {61'd0, res_byte}, 64'(addr % 8));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state and idle cycle
    check("R10", "reset valid", {63'd0, res_valid}, 64'd0);
    check("R10", "reset fault", {63'd0, res_fault}, 64'd0);

    // R1 / R5: destination truncation for each code, hand values
    run("R1", 0, 0, 2'd0, 2'd0, 2'd1, 64'h1234, 64'h0001, 12'd0, 7'd0, 10'd0);
    check("R1", "byte dest", res_data, 64'h35);
    run("R1", 0, 0, 2'd0, 2'd0, 2'd2, 64'h1_2345, 64'h1, 12'd0, 7'd0, 10'd0);
    check("R1", "half dest", res_data, 64'h2346);
    // R2 / R3: plain add zero-extends a negative-looking byte
    run("R3", 0, 0, 2'd1, 2'd2, 2'd2, 64'hFF, 64'h0001, 12'd0, 7'd2, 10'd3);
    check("R3", "zero ext", res_data, 64'h0100);
    // R4: word add sign-extends the byte
    run("R4", 1, 0, 2'd1, 2'd2, 2'd2, 64'hFF, 64'h0001, 12'd0, 7'd2, 10'd3);
    check("R4", "sign ext", res_data, 64'h0000);
    // R2: wrap at 8-bit op width, R5 sign-extend to 32
    run("R2", 0, 0, 2'd1, 2'd1, 2'd3, 64'hF0, 64'h20, 12'd0, 7'd5, 10'd1);
    check("R2", "wrap", res_data, 64'h10);
    run("R5", 0, 0, 2'd1, 2'd1, 2'd3, 64'h70, 64'h20, 12'd0, 7'd5, 10'd1);
    check("R5", "widen", res_data, 64'hFFFF_FF90);
    // R6: immediate, word_mode ignored, byte source op width 12
    run("R6", 0, 1, 2'd1, 2'd0, 2'd2, 64'h80, 64'h0, 12'hFFF, 7'd0, 10'd0);
    check("R6", "imm", res_data, 64'hFF7F);
    run("R6", 1, 1, 2'd1, 2'd0, 2'd2, 64'h80, 64'h0, 12'hFFF, 7'd0, 10'd0);
    check("R6", "imm wm", res_data, 64'hFF7F);
    // R7: junk above source width ignored
    run("R7", 0, 0, 2'd1, 2'd1, 2'd0, 64'hDEAD_BE01, 64'hAB02, 12'd0, 7'd0, 10'd0);
    check("R7", "junk", res_data, 64'h03);
    // R8: spill into following registers
    run("R8", 0, 0, 2'd2, 2'd2, 2'd2, 64'h1, 64'h1, 12'd0, 7'd10, 10'd9);
    check("R8", "reg", {57'd0, res_reg}, 64'd12);
    check("R8", "byte", {61'd0, res_byte}, 64'd2);
    // R9: last element fits, next overruns; fault cancels valid
    run("R9", 0, 0, 2'd0, 2'd0, 2'd3, 64'h5, 64'h6, 12'd0, 7'd127, 10'd1);
    run("R9", 0, 0, 2'd0, 2'd0, 2'd3, 64'h5, 64'h6, 12'd0, 7'd127, 10'd2);
    run("R9", 0, 0, 2'd0, 2'd0, 2'd0, 64'h5, 64'h6, 12'd0, 7'd120, 10'd8);
    run("R9", 1, 0, 2'd1, 2'd1, 2'd1, 64'h5, 64'h6, 12'd0, 7'd0, 10'd1023);
    // R10: idle cycle after requests
    @(negedge clk);
    check("R10", "idle valid", {63'd0, res_valid}, 64'd0);
    check("R10", "idle fault", {63'd0, res_fault}, 64'd0);

    // mixed patterns across all codes and modes
    for (int k = 0; k < 400; k++) begin
      run("R4", 1'($urandom), 1'($urandom % 4 == 0),
          2'($urandom), 2'($urandom), 2'($urandom),
          {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)},
          12'($urandom), 7'($urandom), 10'($urandom % 64));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule